// File: doc/BRIEF.md
# MSI-X Vector Table Dispatcher

This block holds a small table of message-signalled interrupt vectors and an array of pending bits. Device logic raises an interrupt by giving a vector number. The block then issues a single memory-write message on a valid/ready output port. The message carries a 64-bit address and a 32-bit data word, both taken from that vector's table entry. A vector can be masked by its own control bit or by a function-wide mask input. A request to a masked vector is not lost: it is remembered as a pending bit. The block sends that message once the vector becomes unmasked.

All requests pass through the pending array. In each cycle where the output register is free, a scheduler takes the lowest-numbered vector that is pending and not masked. It loads that vector's message and clears the vector's pending bit. Because of this, requests that arrive while the output is stalled wait in the pending array and are sent later. Software reads and writes the table through a plain dword register port, and it can read the pending array through the same port.

Top module: `msix_dispatch`

## Requirements
- R1: After reset, the block drives no message (msg_valid low) and every pending bit reads 0. Every vector-control dword reads 1, which means the vector is masked. All address and data dwords read 0.
- R2: A request whose vector number is NUM_VEC or greater changes no pending bit and produces no message.
- R3: A request for a vector whose vec_used bit is 0 changes no pending bit and produces no message.
- R4: A vector is masked when func_mask is 1, or when bit 0 of its vector-control dword is 1.
- R5: A request to a masked vector sets that vector's pending bit and produces no message.
- R6: A request to an unmasked vector produces exactly one message. msg_valid rises after the second rising edge that follows the sampled request. msg_addr is the upper address dword concatenated with the lower address dword, and msg_data is the entry's data dword.
- R7: The register port has two regions. With address bit AW-1 at 0, it reaches the table: entry v sits at byte 16*v, with the lower address at +0, the upper address at +4, the data at +8 and the control dword at +12 (only bit 0 is kept). With address bit AW-1 at 1, it reaches the pending array: dword k holds vectors 32k to 32k+31, with vector N at bit N mod 32. Writes to the pending array are ignored.
- R8: Register reads and writes ignore address bits 1:0.
- R9: When a vector with its pending bit set becomes unmasked, the block sends that vector's message exactly once and clears the pending bit.
- R10: While msg_valid is 1 and msg_ready is 0, msg_addr and msg_data hold steady. Requests that arrive during the stall are kept as pending bits. They are sent afterwards, lowest vector number first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | AW | Byte address for register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| func_mask | input | 1 | Function-wide mask |
| vec_used | input | NUM_VEC | Marks each vector as in use |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | VEC_W | Requested vector number |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Every request leaves a trace within two cycles: either a message appears, or a bit shows up in the pending array. A request that is wrongly counted as masked or unmasked therefore shows at the ports almost at once. A pending bit that is never cleared shows up as a repeated message when the vector is unmasked. A pending bit that is wrongly dropped shows up as a missing message, or as a pending dword that reads differently from the value worked out from the request history. A corrupted message register shows up as a changing address during a stall.

// File: rtl/msix_dispatch.sv
module msix_dispatch #(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = 8,
  localparam int AW     = $clog2(NUM_VEC * 16) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               func_mask,
  input  logic [NUM_VEC-1:0] vec_used,
  input  logic               irq_req,
  input  logic [VEC_W-1:0]   irq_vec,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam int IW  = $clog2(NUM_VEC);
  localparam int PDW = (NUM_VEC + 31) / 32;
  localparam int PIW = AW - 3;

  logic [31:0]        t_lo  [NUM_VEC];
  logic [31:0]        t_hi  [NUM_VEC];
  logic [31:0]        t_dat [NUM_VEC];
  logic [NUM_VEC-1:0] t_msk;
  logic [NUM_VEC-1:0] pend;

  logic [NUM_VEC-1:0] vmask, elig, set_vec, clr_vec;
  logic [IW-1:0]      sel;
  logic               req_ok, can_load, load;

  wire          in_pba = reg_addr[AW-1];
  wire [IW-1:0] r_vec  = reg_addr[AW-2:4];
  wire [1:0]    r_dw   = reg_addr[3:2];
  wire [PIW-1:0] r_pdw = reg_addr[AW-2:2];
  wire          r_vec_ok = int'(r_vec) < NUM_VEC;

  assign vmask    = {NUM_VEC{func_mask}} | t_msk;
  assign elig     = pend & ~vmask;
  assign req_ok   = irq_req && (int'(irq_vec) < NUM_VEC) && vec_used[irq_vec[IW-1:0]];
  assign set_vec  = req_ok ? (NUM_VEC'(1) << irq_vec[IW-1:0]) : '0;
  assign can_load = !msg_valid || msg_ready;
  assign load     = can_load && (|elig);
  assign clr_vec  = load ? (NUM_VEC'(1) << sel) : '0;

  always_comb begin
    sel = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--)
      if (elig[i]) sel = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        t_lo[i]  <= '0;
        t_hi[i]  <= '0;
        t_dat[i] <= '0;
      end
      t_msk <= '1;
    end else if (reg_wr && !in_pba && r_vec_ok) begin
      case (r_dw)
        2'd0: t_lo[r_vec]  <= reg_wdata;
        2'd1: t_hi[r_vec]  <= reg_wdata;
        2'd2: t_dat[r_vec] <= reg_wdata;
        default: t_msk[r_vec] <= reg_wdata[0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= {t_hi[sel], t_lo[sel]};
      msg_data  <= t_dat[sel];
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  logic [PDW*32-1:0] pend_pad;
  assign pend_pad = (PDW*32)'(pend);

  always_comb begin
    reg_rdata = '0;
    if (in_pba) begin
      if (int'(r_pdw) < PDW) reg_rdata = pend_pad[int'(r_pdw)*32 +: 32];
    end else if (r_vec_ok) begin
      case (r_dw)
        2'd0: reg_rdata = t_lo[r_vec];
        2'd1: reg_rdata = t_hi[r_vec];
        2'd2: reg_rdata = t_dat[r_vec];
        default: reg_rdata = {31'b0, t_msk[r_vec]};
      endcase
    end
  end

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  p_range_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && int'(irq_vec) >= NUM_VEC) |=> ((pend & ~$past(pend)) == '0));

  p_unused_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && int'(irq_vec) < NUM_VEC && !vec_used[irq_vec[IW-1:0]])
      |=> ((pend & ~$past(pend)) == '0));

  p_masked_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(pend & vmask) & ~pend) == '0));

  p_single_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend) & ~pend) != '0) |-> (msg_valid && $countones($past(pend) & ~pend) == 1));
endmodule

// File: tb/msix_dispatch_test.sv
module msix_dispatch_test;
  localparam int CLK = 10;
  localparam int NV  = 8;
  localparam int AW  = $clog2(NV * 16) + 1;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic func_mask = 0;
  logic [NV-1:0] vec_used = 8'hBF;
  logic irq_req = 0;
  logic [7:0] irq_vec = '0;
  logic msg_valid, msg_ready = 1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  msix_dispatch #(.NUM_VEC(NV), .VEC_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .func_mask(func_mask),
    .vec_used(vec_used), .irq_req(irq_req), .irq_vec(irq_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data));

  always #(CLK/2) clk = ~clk;

  int n_run = 0, n_fail = 0, n_msg = 0;
  logic [63:0] log_a [64];
  logic [31:0] log_d [64];

  always @(posedge clk)
    if (rst_n && msg_valid && msg_ready) begin
      log_a[n_msg % 64] = msg_addr;
      log_d[n_msg % 64] = msg_data;
      n_msg = n_msg + 1;
    end

  function automatic logic [63:0] exp_a(int v);
    return {32'hA0 + 32'(v), 32'h1000_0000 + 32'(v * 16)};
  endfunction
  function automatic logic [31:0] exp_d(int v);
    return 32'hD000 + 32'(v);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic req(int v);
    @(negedge clk);
    irq_req = 1; irq_vec = 8'(v);
    @(negedge clk);
    irq_req = 0;
  endtask

  // {expected pending dword [7:0], expects message, vector}
  localparam logic [16:0] ROWS [8] = '{
    {8'h00, 1'b1, 8'd0},
    {8'h00, 1'b1, 8'd5},
    {8'h08, 1'b0, 8'd3},
    {8'h08, 1'b0, 8'd6},
    {8'h08, 1'b0, 8'd8},
    {8'h08, 1'b0, 8'd200},
    {8'h08, 1'b1, 8'd7},
    {8'h08, 1'b1, 8'd1}
  };

  initial begin
    #(CLK * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 valid", 64'(msg_valid), 0);
    rd(32'h0C, d); check("R1 ctrl", 64'(d), 1);
    rd(32'h74, d); check("R1 hi", 64'(d), 0);
    rd(32'h80, d); check("R1 pend", 64'(d), 0);

    for (int v = 0; v < NV; v++) begin
      wr(v*16 + 0, exp_a(v)[31:0]);
      wr(v*16 + 4, exp_a(v)[63:32]);
      wr(v*16 + 8, exp_d(v));
      wr(v*16 + 12, (v == 3) ? 32'd1 : 32'd0);
    end

    // R8 low address bits ignored
    rd(32'h33, d); check("R8 read", 64'(d), 64'(exp_a(3)[31:0]));
    rd(32'h0D, d); check("R8 ctrl", 64'(d), 0);

    // R2 R3 R5 R6 vector table walk
    for (int i = 0; i < 8; i++) begin
      base = n_msg;
      req(int'(ROWS[i][7:0]));
      repeat (4) @(negedge clk);
      check("R6/R5/R2/R3 count", 64'(n_msg - base), 64'(ROWS[i][8]));
      if (ROWS[i][8]) begin
        check("R6 addr", log_a[base % 64], exp_a(int'(ROWS[i][7:0])));
        check("R6 data", 64'(log_d[base % 64]), 64'(exp_d(int'(ROWS[i][7:0]))));
      end
      rd(32'h80, d); check("R7 pend", 64'(d), 64'(ROWS[i][16:9]));
    end

    // R7 pending writes ignored
    wr(32'h80, 32'hFF); rd(32'h80, d); check("R7 wr ignored", 64'(d), 64'h08);

    // R9 replay on unmask, exactly once
    base = n_msg;
    wr(32'h3C, 32'd0);
    repeat (4) @(negedge clk);
    check("R9 count", 64'(n_msg - base), 1);
    check("R9 addr", log_a[base % 64], exp_a(3));
    rd(32'h80, d); check("R9 pend", 64'(d), 0);
    repeat (6) @(negedge clk);
    check("R9 once", 64'(n_msg - base), 1);

    // R4 function-wide mask
    base = n_msg;
    func_mask = 1;
    req(2);
    repeat (4) @(negedge clk);
    check("R4 masked count", 64'(n_msg - base), 0);
    rd(32'h80, d); check("R4 pend", 64'(d), 64'h04);
    func_mask = 0;
    repeat (4) @(negedge clk);
    check("R4 replay", 64'(n_msg - base), 1);
    check("R4 addr", log_a[base % 64], exp_a(2));

    // R10 stall
    base = n_msg;
    msg_ready = 0;
    req(4);
    repeat (2) @(negedge clk);
    check("R10 valid", 64'(msg_valid), 1);
    check("R10 addr", msg_addr, exp_a(4));
    req(2); req(1);
    repeat (3) @(negedge clk);
    check("R10 hold", msg_addr, exp_a(4));
    check("R10 hold data", 64'(msg_data), 64'(exp_d(4)));
    rd(32'h80, d); check("R10 pend", 64'(d), 64'h06);
    msg_ready = 1;
    repeat (6) @(negedge clk);
    check("R10 count", 64'(n_msg - base), 3);
    check("R10 first", log_a[base % 64], exp_a(4));
    check("R10 second", log_a[(base + 1) % 64], exp_a(1));
    check("R10 third", log_a[(base + 2) % 64], exp_a(2));
    check("R10 idle", 64'(msg_valid), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule